// File: doc/BRIEF.md
# Stereo ADC Channel Router and Serial Port

This block sits between a stereo converter's parallel sample path and a three-wire serial audio link. A new left/right pair of signed 16-bit samples is taken once per frame. A routing stage is set by two channel-enable bits and a mix bit. It can silence both channels, copy one channel to both outputs, pass the pair straight through, or replace both channels with their average. The routed pair is then shifted out MSB first on `sdo`. The word clock `wclk` frames the data: its low half carries the left word and its high half carries the right word. The first data bit follows each word-clock change by one bit-clock period.

The same framing runs in the other direction. The block reads `sdi` and rebuilds a left/right pair of parallel words. It presents the pair with a one-cycle `rx_valid` pulse. Bit-clock edges arrive as single-cycle strobes (`bck_fall`, `bck_rise`) in the system clock domain. `wclk` is a level that changes on fall-strobe cycles. The block works out from the word clock whether the frame is 32 or 64 bit clocks long, so no mode pin is needed.

Each direction has its own slot tracker with three states:
- SL_IDLE: no word-clock change seen yet since reset.
- SL_DATA: slots 0 to 16 of a half-frame.
- SL_PAD: slots 17 and up.

The transitions are:
- Any state goes to SL_DATA at slot 0 on a strobe that sees `wclk` differ from its stored value.
- SL_DATA goes to SL_PAD on the strobe that leaves slot 16.
- SL_PAD counts up, saturating at the last slot, until the next word-clock change.
- SL_IDLE stays in SL_IDLE until the first word-clock change.

Top module: `stereo_route_serdes`

## Requirements
- R1: With `en_left`=0 and `en_right`=0, both transmitted words are 0x0000.
- R2: With only `en_right`=1, both transmitted words equal `adc_right`, whatever the value of `mix`.
- R3: With only `en_left`=1, both transmitted words equal `adc_left`, whatever the value of `mix`.
- R4: With both enables at 1 and `mix`=0, the left word is `adc_left` and the right word is `adc_right`.
- R5: With both enables at 1 and `mix`=1, both words are (adc_left + adc_right) taken as a 17-bit signed sum and shifted right arithmetically by one. Examples: 0x7FFF+0x7FFF gives 0x7FFF, 0x8000+0x8000 gives 0x8000, and 0xFFFF+0x0000 gives 0xFFFF.
- R6: `sdo` changes only on `bck_fall` cycles. Each word is sent MSB first, with bit 15 in slot 1 through bit 0 in slot 16 of its half-frame. Slot 0 is the slot that starts where `wclk` changes. The left word is sent while `wclk`=0 and the right word while `wclk`=1.
- R7: With 16 slots per half (32 bit clocks per frame), bit 0 of a word is carried in slot 0 of the following half-frame.
- R8: With 32 slots per half (64 bit clocks per frame), `sdo` is 0 in slots 17 to 31 and in slot 0. `sdi` values in those slots have no effect on the received words.
- R9: The routed pair is latched on the `bck_fall` where `wclk` goes from 1 to 0. Changes to enables, `mix` or samples after that edge affect only the next frame.
- R10: `sdi` is sampled on `bck_rise` cycles using the same slot positions as R6 and R7. Once the right word's bit 0 is captured, `rx_left`/`rx_right` update and `rx_valid` is high for exactly one cycle.
- R11: After reset, `sdo`, `rx_valid`, `rx_left` and `rx_right` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bck_fall | input | 1 | Bit-clock falling-edge strobe |
| bck_rise | input | 1 | Bit-clock rising-edge strobe |
| wclk | input | 1 | Word clock level (0 = left, 1 = right) |
| en_left | input | 1 | Left channel enable |
| en_right | input | 1 | Right channel enable |
| mix | input | 1 | Average both channels when both enabled |
| adc_left | input | 16 | Left parallel sample |
| adc_right | input | 16 | Right parallel sample |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rx_left | output | 16 | Deserialized left word |
| rx_right | output | 16 | Deserialized right word |
| rx_valid | output | 1 | One-cycle pulse when a new pair is ready |

## Verification
In 32-clock framing, three events happen in the same bit slot:
- the previous right word's bit 0 leaves on `sdo`;
- the new frame latches its routed pair from the inputs;
- on the receive side, the right word completes and `rx_valid` pulses.

The bench provokes this by running 32-clock frames back to back, each with a different routing setting and sample pair. It also switches between 32- and 64-clock frames, so slot 0 alternates between carrying a spilled bit 0 and being padding. A scoreboard queue holds the expected words from the bench's own routing model. The monitors rebuild the serial words slot by slot and rate a frame correct only if the spilled bit belongs to the old word while the new pair leaves untouched.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_DATA = 2'd1,
        SL_PAD  = 2'd2
    } slot_state_t;
endpackage

// File: rtl/srs_route.sv
module srs_route #(
    parameter int DATA_W = 16
) (
    input  logic              en_l,
    input  logic              en_r,
    input  logic              mix,
    input  logic [DATA_W-1:0] in_l,
    input  logic [DATA_W-1:0] in_r,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r
);
    logic [DATA_W:0] sum;

    // sign-extended sum, one bit wider so it never overflows
    assign sum = {in_l[DATA_W-1], in_l} + {in_r[DATA_W-1], in_r};

    always_comb begin
        unique case ({en_l, en_r})
            2'b00: begin out_l = '0;   out_r = '0;   end
            2'b01: begin out_l = in_r; out_r = in_r; end
            2'b10: begin out_l = in_l; out_r = in_l; end
            default: begin
                if (mix) begin
                    out_l = sum[DATA_W:1];
                    out_r = sum[DATA_W:1];
                end else begin
                    out_l = in_l;
                    out_r = in_r;
                end
            end
        endcase
    end
endmodule

// File: rtl/srs_slot_fsm.sv
module srs_slot_fsm
    import srs_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_SLOTS = 32,
    parameter int SLOT_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              wclk,
    output logic              edge_o,
    output slot_state_t       cur_st,
    output slot_state_t       nxt_st,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [SLOT_W-1:0] nxt_slot,
    output logic              half_q
);
    assign edge_o = stb && (wclk != half_q);

    always_comb begin
        nxt_st   = cur_st;
        nxt_slot = cur_slot;
        if (edge_o) begin
            nxt_st   = SL_DATA;
            nxt_slot = '0;
        end else if (stb) begin
            unique case (cur_st)
                SL_IDLE: nxt_st = SL_IDLE;
                SL_DATA: begin
                    nxt_slot = cur_slot + 1'b1;
                    if (cur_slot == SLOT_W'(DATA_W))
                        nxt_st = SL_PAD;
                end
                SL_PAD: begin
                    if (cur_slot != SLOT_W'(MAX_SLOTS - 1))
                        nxt_slot = cur_slot + 1'b1;
                end
                default: nxt_st = SL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_st   <= SL_IDLE;
            cur_slot <= '0;
            half_q   <= 1'b1;
        end else begin
            cur_st   <= nxt_st;
            cur_slot <= nxt_slot;
            if (stb)
                half_q <= wclk;
        end
    end
endmodule

// File: rtl/srs_tx.sv
module srs_tx
    import srs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              edge_i,
    input  logic              wclk,
    input  logic              half_q,
    input  slot_state_t       cur_st,
    input  slot_state_t       nxt_st,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic [SLOT_W-1:0] nxt_slot,
    input  logic [DATA_W-1:0] pair_l,
    input  logic [DATA_W-1:0] pair_r,
    output logic              sdo
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] word_l, word_r, cur_word;
    logic [IDX_W-1:0]  idx;
    logic              frame_start, sdo_d;

    assign frame_start = edge_i && !wclk;
    assign cur_word    = half_q ? word_r : word_l;
    assign idx         = IDX_W'(SLOT_W'(DATA_W) - nxt_slot);

    always_comb begin
        sdo_d = sdo;
        if (stb) begin
            if (edge_i)
                sdo_d = (cur_st == SL_DATA && cur_slot == SLOT_W'(DATA_W - 1))
                        ? cur_word[0] : 1'b0;
            else if (nxt_st == SL_DATA)
                sdo_d = cur_word[idx];
            else
                sdo_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo    <= 1'b0;
            word_l <= '0;
            word_r <= '0;
        end else begin
            sdo <= sdo_d;
            if (frame_start) begin
                word_l <= pair_l;
                word_r <= pair_r;
            end
        end
    end

    // R6
    sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(sdo));

    // R8
    pad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == SL_PAD) |-> !sdo);

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(word_l) && $stable(word_r)));
endmodule

// File: rtl/srs_rx.sv
module srs_rx
    import srs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              edge_i,
    input  logic              wclk,
    input  logic              half_q,
    input  slot_state_t       cur_st,
    input  slot_state_t       nxt_st,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic [SLOT_W-1:0] nxt_slot,
    input  logic              sdi,
    output logic [DATA_W-1:0] rx_l,
    output logic [DATA_W-1:0] rx_r,
    output logic              rx_valid
);
    logic [DATA_W-1:0] shreg, shreg_d, hold_l, done_word;
    logic              done, done_half;

    assign done_word = {shreg[DATA_W-2:0], sdi};

    always_comb begin
        shreg_d   = shreg;
        done      = 1'b0;
        done_half = 1'b0;
        if (stb) begin
            if (edge_i) begin
                if (cur_st == SL_DATA && cur_slot == SLOT_W'(DATA_W - 1)) begin
                    done      = 1'b1;
                    done_half = half_q;
                end
            end else if (nxt_st == SL_DATA) begin
                shreg_d = done_word;
                if (nxt_slot == SLOT_W'(DATA_W)) begin
                    done      = 1'b1;
                    done_half = wclk;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            hold_l   <= '0;
            rx_l     <= '0;
            rx_r     <= '0;
            rx_valid <= 1'b0;
        end else begin
            shreg    <= shreg_d;
            rx_valid <= 1'b0;
            if (done) begin
                if (!done_half) begin
                    hold_l <= done_word;
                end else begin
                    rx_l     <= hold_l;
                    rx_r     <= done_word;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(stb));
endmodule

// File: rtl/stereo_route_serdes.sv
module stereo_route_serdes
    import srs_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_SLOTS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_fall,
    input  logic              bck_rise,
    input  logic              wclk,
    input  logic              en_left,
    input  logic              en_right,
    input  logic              mix,
    input  logic [DATA_W-1:0] adc_left,
    input  logic [DATA_W-1:0] adc_right,
    output logic              sdo,
    input  logic              sdi,
    output logic [DATA_W-1:0] rx_left,
    output logic [DATA_W-1:0] rx_right,
    output logic              rx_valid
);
    localparam int SLOT_W = $clog2(MAX_SLOTS) + 1;

    logic [DATA_W-1:0] rt_l, rt_r;
    logic              t_edge, r_edge, t_half, r_half;
    slot_state_t       t_cur, t_nxt, r_cur, r_nxt;
    logic [SLOT_W-1:0] t_slot, t_slot_n, r_slot, r_slot_n;

    srs_route #(.DATA_W(DATA_W)) u_route (
        .en_l(en_left), .en_r(en_right), .mix(mix),
        .in_l(adc_left), .in_r(adc_right),
        .out_l(rt_l), .out_r(rt_r)
    );

    // R2
    mono_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_left && en_right && !mix) |-> (rt_l == rt_r));

    // R1
    silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_left && !en_right) |-> (rt_l == '0));

    srs_slot_fsm #(.DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_tx_fsm (
        .clk(clk), .rst_n(rst_n), .stb(bck_fall), .wclk(wclk),
        .edge_o(t_edge), .cur_st(t_cur), .nxt_st(t_nxt),
        .cur_slot(t_slot), .nxt_slot(t_slot_n), .half_q(t_half)
    );

    srs_slot_fsm #(.DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_rx_fsm (
        .clk(clk), .rst_n(rst_n), .stb(bck_rise), .wclk(wclk),
        .edge_o(r_edge), .cur_st(r_cur), .nxt_st(r_nxt),
        .cur_slot(r_slot), .nxt_slot(r_slot_n), .half_q(r_half)
    );

    srs_tx #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .stb(bck_fall), .edge_i(t_edge),
        .wclk(wclk), .half_q(t_half), .cur_st(t_cur), .nxt_st(t_nxt),
        .cur_slot(t_slot), .nxt_slot(t_slot_n),
        .pair_l(rt_l), .pair_r(rt_r), .sdo(sdo)
    );

    srs_rx #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .stb(bck_rise), .edge_i(r_edge),
        .wclk(wclk), .half_q(r_half), .cur_st(r_cur), .nxt_st(r_nxt),
        .cur_slot(r_slot), .nxt_slot(r_slot_n), .sdi(sdi),
        .rx_l(rx_left), .rx_r(rx_right), .rx_valid(rx_valid)
    );
endmodule

// File: tb/sim_stereo_route_serdes.sv
module sim_stereo_route_serdes;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck_fall = 1'b0, bck_rise = 1'b0, wclk = 1'b1;
    logic        en_left = 1'b0, en_right = 1'b0, mix = 1'b0, sdi = 1'b0;
    logic [15:0] adc_left = '0, adc_right = '0;
    logic        sdo, rx_valid;
    logic [15:0] rx_left, rx_right;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    logic [15:0] txq[$];
    int          txtag[$];
    logic [31:0] rxq[$];

    logic [15:0] last_w = '0;
    int          last_n = 0;

    // transmit monitor state
    bit          m_sync = 1'b0;
    logic        m_half = 1'b1;
    int          m_slot = 0;
    logic [15:0] m_sh = '0;

    always #2 clk = ~clk;

    stereo_route_serdes u0 (
        .clk(clk), .rst_n(rst_n), .bck_fall(bck_fall), .bck_rise(bck_rise),
        .wclk(wclk), .en_left(en_left), .en_right(en_right), .mix(mix),
        .adc_left(adc_left), .adc_right(adc_right), .sdo(sdo), .sdi(sdi),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] route_m(input bit el, input bit er, input bit mx,
                                            input logic [15:0] l, input logic [15:0] r);
        int s;
        logic [15:0] a;
        s = int'($signed(l)) + int'($signed(r));
        s = s >>> 1;
        a = s[15:0];
        if (!el && !er) return 32'h0;          // R1
        if (!el && er)  return {r, r};          // R2
        if (el && !er)  return {l, l};          // R3
        if (!mx)        return {l, r};          // R4
        return {a, a};                          // R5
    endfunction

    task automatic tx_done(input logic [15:0] got);
        if (txq.size() == 0) begin
            chk(1'b0, 6, {16'h0, got}, 32'hFFFF_FFFF);
        end else begin
            logic [15:0] e;
            int t;
            e = txq.pop_front();
            t = txtag.pop_front();
            chk(got == e, t, {16'h0, got}, {16'h0, e});
        end
    endtask

    // transmit monitor: rebuilds words from sdo at each rise strobe
    always @(posedge clk) begin
        #1;
        if (rst_n && bck_rise) begin
            if (wclk != m_half) begin
                if (m_sync && m_slot == 15)
                    tx_done({m_sh[14:0], sdo});              // R7 spilled bit 0
                else if (m_sync)
                    chk(sdo == 1'b0, 8, {31'h0, sdo}, 32'h0); // R8 slot 0 padding
                m_sync = 1'b1;
                m_slot = 0;
                m_half = wclk;
            end else if (m_sync) begin
                m_slot++;
                if (m_slot <= 16) begin
                    m_sh = {m_sh[14:0], sdo};                // R6 MSB first
                    if (m_slot == 16) tx_done(m_sh);
                end else begin
                    chk(sdo == 1'b0, 8, {31'h0, sdo}, 32'h0); // R8 pad slots
                end
            end
        end
    end

    // receive monitor
    always @(posedge clk) begin
        #1;
        if (rst_n && rx_valid) begin
            if (rxq.size() == 0) begin
                chk(1'b0, 10, {rx_left, rx_right}, 32'hFFFF_FFFF);
            end else begin
                logic [31:0] e;
                e = rxq.pop_front();
                chk({rx_left, rx_right} == e, 10, {rx_left, rx_right}, e); // R10
            end
        end
    end

    task automatic run_frame(input int n, input bit el, input bit er, input bit mx,
                             input logic [15:0] l, input logic [15:0] r,
                             input logic [15:0] sl, input logic [15:0] sr,
                             input int tag, input bit midchg);
        logic [31:0] e;
        logic [15:0] w;
        logic        b;
        en_left = el; en_right = er; mix = mx; adc_left = l; adc_right = r;
        e = route_m(el, er, mx, l, r);
        txq.push_back(e[31:16]); txtag.push_back(tag);
        txq.push_back(e[15:0]);  txtag.push_back(tag);
        rxq.push_back({sl, sr});
        for (int h = 0; h < 2; h++) begin
            w = (h == 1) ? sr : sl;
            for (int s = 0; s < n; s++) begin
                if (s >= 1 && s <= 16)          b = w[16-s];
                else if (s == 0 && last_n == 16) b = last_w[0];
                else                             b = 1'b1;   // R8: junk in padding
                @(negedge clk);
                bck_rise = 1'b0; bck_fall = 1'b1; wclk = h[0]; sdi = b;
                @(negedge clk);
                bck_fall = 1'b0;
                if (midchg && h == 1 && s == 4) begin        // R9 mid-frame change
                    mix = ~mix; adc_left = ~adc_left; adc_right = ~adc_right;
                end
                @(negedge clk);
                bck_rise = 1'b1;
            end
            last_w = w;
            last_n = n;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R6: watchdog, actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(sdo == 1'b0, 11, {31'h0, sdo}, 32'h0);
        chk(rx_valid == 1'b0, 11, {31'h0, rx_valid}, 32'h0);
        chk({rx_left, rx_right} == 32'h0, 11, {rx_left, rx_right}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_frame(16, 1, 1, 0, 16'h1234, 16'hABCD, 16'hA5A5, 16'h5A5A, 4, 0); // R4 R7
        run_frame(32, 0, 0, 1, 16'h7777, 16'h1111, 16'h8001, 16'h7FFE, 1, 0); // R1 R8
        run_frame(16, 0, 1, 1, 16'h0F0F, 16'hC3C3, 16'h1357, 16'h2468, 2, 0); // R2
        run_frame(32, 1, 0, 1, 16'h4242, 16'h9999, 16'hFFFF, 16'h0001, 3, 0); // R3
        run_frame(16, 1, 1, 1, 16'h7FFF, 16'h7FFF, 16'h0000, 16'hFFFF, 5, 0); // R5
        run_frame(32, 1, 1, 1, 16'h8000, 16'h8000, 16'hDEAD, 16'hBEEF, 5, 0); // R5
        run_frame(16, 1, 1, 1, 16'hFFFF, 16'h0000, 16'h8000, 16'h0001, 5, 0); // R5
        run_frame(32, 1, 1, 1, 16'h0003, 16'h0004, 16'h1111, 16'h2222, 5, 0); // R5
        run_frame(16, 1, 1, 0, 16'h6001, 16'h0180, 16'hCAFE, 16'hF00D, 9, 1); // R9
        run_frame(16, 1, 1, 1, 16'h0100, 16'h0300, 16'h3C3C, 16'hC3C3, 9, 0); // R9 next frame
        run_frame(32, 1, 1, 0, 16'h8421, 16'h1248, 16'h0F0F, 16'hF0F0, 6, 0); // R6 R10
        @(negedge clk);
        bck_rise = 1'b0;
        repeat (20) @(negedge clk);

        chk(txq.size() == 0, 6, txq.size(), 32'h0);   // R6 all words seen
        chk(rxq.size() == 0, 10, rxq.size(), 32'h0);  // R10 all pairs seen
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule